// File: doc/BRIEF.md
# Two-Wire Slave Controller with Event Status Codes

This block is the slave side of a two-wire serial bus (I2C), run by a host through a small write port. It recognises its own 7-bit address. It receives bytes from a bus master, or sends bytes to one. Each bus event that needs the host raises an interrupt flag and puts a fixed 8-bit code on the status output. While no flag is pending, the status output shows a neutral code.

An acknowledge-enable control bit decides whether the slave answers at all. When the host clears it, the slave stops answering its own address. During a read, the byte already under way is still sent, and then the slave leaves the transfer. Throughout, it keeps watching the bus for START, STOP and address bytes. A START or STOP inside a byte or an acknowledge bit is a bus error. The host recovers from it by setting a stop-request bit and clearing the flag in one write. SCL and SDA are modelled as open-drain pads: the block only ever pulls a line low.

The host port decodes `host_addr` as follows: 0 is control, 1 is the own address (low 7 bits), and 2 is the byte to transmit. A control write uses these bits: bit 0 is acknowledge enable, bit 1 written as 0 clears the interrupt flag (written as 1 it has no effect), and bit 2 is the stop request. `ctrl_rd` reads back {stop request, flag, acknowledge enable} in bits [2:0].

Top module: `i2c_status_slave`

## Requirements
- R1: After reset, status is F8h, the flag is 0, neither line is pulled low, and `ctrl_rd` is 00h.
- R2: An address byte carrying the own address with a write bit (0), received while acknowledge enable is 1, is answered with ACK (SDA low in the ninth clock). At the end of that clock the slave raises the flag with status 60h.
- R3: A data byte received with acknowledge enable 1 is answered with ACK and gives status 80h, with the byte on `rx_data`. With acknowledge enable 0 the slave answers NACK, gives status 88h and then becomes not addressed, so a later STOP raises no flag.
- R4: The own address with a read bit (1) gives ACK and status A8h. After the host clears the flag, the loaded transmit byte is shifted out MSB first.
- R5: After a sent byte, a master ACK gives status B8h while acknowledge enable is 1. A master NACK gives C0h and the slave becomes not addressed.
- R6: If acknowledge enable is cleared while transmitting, the current byte is still sent. A master ACK then gives C8h. After that the slave leaves SDA released, so further master reads return FFh.
- R7: While acknowledge enable is 0, the own address gets NACK and no flag. Once the bit is set again, the next address is recognised.
- R8: A STOP or a repeated START at a byte boundary while addressed gives status A0h.
- R9: A START or STOP after the first bit of an address or data byte has been clocked gives status 00h with the flag set, and SCL is not held.
- R10: After a bus error, one control write with the stop request set and the flag cleared returns the slave to not-addressed mode. The stop request self-clears, acknowledge enable is kept, both lines stay released, and the next address is recognised.
- R11: Status is F8h whenever the flag is 0.
- R12: After an address or data event the slave holds SCL low until the host clears the flag.
- R13: An address byte that is not the own address gets NACK and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sensed SCL bus level |
| sda_in | input | 1 | Sensed SDA bus level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| irq | output | 1 | Serial interrupt flag |
| status | output | 8 | Event status code |
| rx_data | output | 8 | Last received data byte |
| ctrl_rd | output | 8 | Control readback |

## Verification
The hardest states to reach are the ones where the master breaks the framing: a STOP after a few data bits, and a START in the middle of an address. A normal master never produces them. The bench therefore drives the bus through a behavioural master built from bit-level tasks. This lets it break off a byte after any number of clocked bits and issue a START or STOP there. The other hard state is the slave leaving a read mid-stream. The bench reaches it by clearing acknowledge enable with the same write that releases the held clock, then clocking a further byte to observe all ones.

// File: rtl/i2c_st_pkg.sv
package i2c_st_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_BERR
  } eng_state_e;

  localparam logic [7:0] CODE_BERR    = 8'h00;
  localparam logic [7:0] CODE_WR_ADDR = 8'h60;
  localparam logic [7:0] CODE_RX_ACK  = 8'h80;
  localparam logic [7:0] CODE_RX_NACK = 8'h88;
  localparam logic [7:0] CODE_STOP    = 8'hA0;
  localparam logic [7:0] CODE_RD_ADDR = 8'hA8;
  localparam logic [7:0] CODE_TX_ACK  = 8'hB8;
  localparam logic [7:0] CODE_TX_NACK = 8'hC0;
  localparam logic [7:0] CODE_TX_LAST = 8'hC8;
  localparam logic [7:0] CODE_NONE    = 8'hF8;

  localparam logic [1:0] HREG_CTRL = 2'd0;
  localparam logic [1:0] HREG_OWN  = 2'd1;
  localparam logic [1:0] HREG_TX   = 2'd2;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;
  logic scl_cur, sda_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_in};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_cur    = scl_ff[STAGES-1];
  assign sda_cur    = sda_ff[STAGES-1];
  assign sda_lvl    = sda_cur;
  assign scl_rise   = scl_cur & ~scl_prev;
  assign scl_fall   = ~scl_cur & scl_prev;
  assign start_seen = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_seen  = scl_cur & scl_prev & ~sda_prev & sda_cur;
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_st_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic [ADDR_W:0]   tx_byte,
  input  logic              clr_irq,
  input  logic              stop_req,
  output logic              irq,
  output logic [7:0]        status,
  output logic [ADDR_W:0]   rx_byte,
  output logic              stop_ack,
  output logic              scl_low,
  output logic              sda_low
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_state_e        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shift, byte_in;
  logic samp, have_bit, rx_ack, mack, rw_q, hold_q;
  logic frozen;

  assign frozen  = irq & hold_q;
  assign byte_in = {shift[BYTE_W-2:0], samp};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shift    <= '0;
      samp     <= 1'b1;
      have_bit <= 1'b0;
      rx_ack   <= 1'b0;
      mack     <= 1'b0;
      rw_q     <= 1'b0;
      hold_q   <= 1'b0;
      irq      <= 1'b0;
      status   <= CODE_NONE;
      rx_byte  <= '0;
      stop_ack <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
    end else begin
      stop_ack <= 1'b0;
      if (clr_irq && irq) begin
        irq    <= 1'b0;
        hold_q <= 1'b0;
        status <= CODE_NONE;
        if (stop_req) begin
          state    <= ST_IDLE;
          stop_ack <= 1'b1;
          have_bit <= 1'b0;
          bitcnt   <= '0;
        end else if (state == ST_TX && hold_q) begin
          shift    <= tx_byte;
          bitcnt   <= '0;
          have_bit <= 1'b0;
        end
      end else if (!frozen) begin
        if (start_seen || stop_seen) begin
          have_bit <= 1'b0;
          case (state)
            ST_IDLE: if (start_seen) begin
              state  <= ST_ADDR;
              bitcnt <= '0;
            end
            ST_ADDR: begin
              if (bitcnt == '0) begin
                state <= start_seen ? ST_ADDR : ST_IDLE;
              end else begin
                state <= ST_BERR; irq <= 1'b1; status <= CODE_BERR; hold_q <= 1'b0;
              end
            end
            ST_RX, ST_TX: begin
              if (bitcnt == '0) begin
                state  <= start_seen ? ST_ADDR : ST_IDLE;
                irq    <= 1'b1;
                status <= CODE_STOP;
                hold_q <= 1'b0;
              end else begin
                state <= ST_BERR; irq <= 1'b1; status <= CODE_BERR; hold_q <= 1'b0;
              end
              bitcnt <= '0;
            end
            ST_ADDR_ACK, ST_RX_ACK, ST_TX_ACK: begin
              state <= ST_BERR; irq <= 1'b1; status <= CODE_BERR; hold_q <= 1'b0;
              bitcnt <= '0;
            end
            default: ;
          endcase
        end else if (scl_rise) begin
          have_bit <= 1'b1;
          samp     <= sda_lvl;
          if (state == ST_TX_ACK) mack <= ~sda_lvl;
        end else if (scl_fall && have_bit) begin
          have_bit <= 1'b0;
          case (state)
            ST_ADDR: begin
              shift  <= byte_in;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                bitcnt <= '0;
                if (ack_en && byte_in[BYTE_W-1:1] == own_addr) begin
                  state <= ST_ADDR_ACK;
                  rw_q  <= byte_in[0];
                end else begin
                  state <= ST_IDLE;
                end
              end
            end
            ST_ADDR_ACK: begin
              irq    <= 1'b1;
              hold_q <= 1'b1;
              status <= rw_q ? CODE_RD_ADDR : CODE_WR_ADDR;
              state  <= rw_q ? ST_TX : ST_RX;
              bitcnt <= '0;
            end
            ST_RX: begin
              shift  <= byte_in;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                bitcnt <= '0;
                rx_ack <= ack_en;
                state  <= ST_RX_ACK;
              end
            end
            ST_RX_ACK: begin
              rx_byte <= shift;
              irq     <= 1'b1;
              hold_q  <= 1'b1;
              status  <= rx_ack ? CODE_RX_ACK : CODE_RX_NACK;
              state   <= rx_ack ? ST_RX : ST_IDLE;
              bitcnt  <= '0;
            end
            ST_TX: begin
              shift  <= {shift[BYTE_W-2:0], 1'b1};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                bitcnt <= '0;
                state  <= ST_TX_ACK;
              end
            end
            ST_TX_ACK: begin
              irq    <= 1'b1;
              hold_q <= 1'b1;
              bitcnt <= '0;
              if (!mack) begin
                status <= CODE_TX_NACK;
                state  <= ST_IDLE;
              end else if (ack_en) begin
                status <= CODE_TX_ACK;
                state  <= ST_TX;
              end else begin
                status <= CODE_TX_LAST;
                state  <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
      scl_low <= frozen;
      sda_low <= (state == ST_ADDR_ACK) || (state == ST_RX_ACK && rx_ack) ||
                 (state == ST_TX && !frozen && !shift[BYTE_W-1]);
    end
  end

  p_scl_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (frozen && $past(frozen)) |-> scl_low);
  p_scl_free_r9: assert property (@(posedge clk) disable iff (rst)
    (!irq && !$past(irq)) |-> !scl_low);
  p_err_code_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BERR && irq) |-> (status == CODE_BERR));
  p_idle_release_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sda_low);
endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
  import i2c_st_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            scl_drive_low,
  output logic            sda_drive_low,
  input  logic            host_wr,
  input  logic [1:0]      host_addr,
  input  logic [ADDR_W:0] host_wdata,
  output logic            irq,
  output logic [7:0]      status,
  output logic [ADDR_W:0] rx_data,
  output logic [ADDR_W:0] ctrl_rd
);
  localparam int BYTE_W = ADDR_W + 1;

  logic sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;
  logic [ADDR_W-1:0] own_q;
  logic [BYTE_W-1:0] tx_q;
  logic ack_en_q, stop_q, stop_ack;
  logic ctrl_wr, clr_irq, stop_req;

  assign ctrl_wr  = host_wr && host_addr == HREG_CTRL;
  assign clr_irq  = ctrl_wr && !host_wdata[1];
  assign stop_req = stop_q || (ctrl_wr && host_wdata[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= '0;
      tx_q     <= '1;
      ack_en_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ack_en_q <= host_wdata[0];
        stop_q   <= host_wdata[2];
      end
      if (stop_ack) stop_q <= 1'b0;
      if (host_wr && host_addr == HREG_OWN) own_q <= host_wdata[ADDR_W-1:0];
      if (host_wr && host_addr == HREG_TX)  tx_q  <= host_wdata;
    end
  end

  assign ctrl_rd = {{(BYTE_W-3){1'b0}}, stop_q, irq, ack_en_q};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2c_slave_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_seen(start_seen), .stop_seen(stop_seen),
    .own_addr(own_q), .ack_en(ack_en_q), .tx_byte(tx_q),
    .clr_irq(clr_irq), .stop_req(stop_req), .irq(irq), .status(status),
    .rx_byte(rx_data), .stop_ack(stop_ack),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  p_idle_code_r11: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (status == CODE_NONE));
  p_stop_clear_r10: assert property (@(posedge clk) disable iff (rst)
    stop_ack |=> !stop_q);
endmodule

// File: tb/test_i2c_status_slave.sv
module test_i2c_status_slave;
  localparam int H = 20;
  localparam int Q = 5;
  localparam logic [7:0] WR_A = 8'hA4;
  localparam logic [7:0] RD_A = 8'hA5;
  localparam logic [16:0] RX_TBL [0:4] = '{
    {8'hA5, 1'b1, 8'h80}, {8'h3C, 1'b1, 8'h80}, {8'hFF, 1'b1, 8'h80},
    {8'h00, 1'b1, 8'h80}, {8'h5A, 1'b0, 8'h88}
  };

  logic clk = 0, rst = 1;
  logic m_scl_low = 0, m_sda_low = 0;
  logic scl_bus, sda_bus, scl_drive_low, sda_drive_low;
  logic host_wr = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic irq;
  logic [7:0] status, rx_data, ctrl_rd;
  int checks = 0, errors = 0;
  logic a;
  logic [7:0] d;

  always #2.5 clk = ~clk;
  assign scl_bus = ~(m_scl_low | scl_drive_low);
  assign sda_bus = ~(m_sda_low | sda_drive_low);

  i2c_status_slave i_i2c_status_slave (
    .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .irq(irq), .status(status), .rx_data(rx_data), .ctrl_rd(ctrl_rd)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] ad, input logic [7:0] dat);
    @(negedge clk); host_wr = 1; host_addr = ad; host_wdata = dat;
    @(negedge clk); host_wr = 0;
    cyc(3);
  endtask

  task automatic m_start();
    m_sda_low = 0; m_scl_low = 0; cyc(H);
    m_sda_low = 1; cyc(H);
    m_scl_low = 1; cyc(Q);
  endtask

  task automatic m_wbit(input logic b);
    m_sda_low = ~b; cyc(H);
    m_scl_low = 0; wait (scl_bus === 1'b1); cyc(H);
    m_scl_low = 1; cyc(Q);
  endtask

  task automatic m_rbit(output logic b);
    m_sda_low = 0; cyc(H);
    m_scl_low = 0; wait (scl_bus === 1'b1); cyc(H/2);
    b = sda_bus; cyc(H/2);
    m_scl_low = 1; cyc(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    m_rbit(ack);
    cyc(10);
  endtask

  task automatic m_rbyte(input logic ackbit, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_rbit(v[i]);
    m_wbit(ackbit);
    cyc(10);
  endtask

  task automatic m_stop();
    m_sda_low = 1; cyc(Q);
    m_scl_low = 0; wait (scl_bus === 1'b1); cyc(H);
    m_sda_low = 0; cyc(H);
  endtask

  task automatic m_rstart();
    m_sda_low = 0; cyc(Q);
    m_scl_low = 0; wait (scl_bus === 1'b1); cyc(H);
    m_sda_low = 1; cyc(H);
    m_scl_low = 1; cyc(Q);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(5); rst = 0; cyc(3);
    chk("R1 status", status, 8'hF8);
    chk("R1 irq", irq, 0);
    chk("R1 drives", {scl_drive_low, sda_drive_low}, 2'b00);
    chk("R1 ctrl", ctrl_rd, 8'h00);

    hw(2'd1, 8'h52);
    hw(2'd0, 8'h01);

    // R13 foreign address
    m_start(); m_wbyte(8'h60, a);
    chk("R13 nack", a, 1); chk("R13 irq", irq, 0);
    m_stop();

    // R2 / R12 write address
    m_start(); m_wbyte(WR_A, a);
    chk("R2 ack", a, 0); chk("R2 status", status, 8'h60); chk("R2 irq", irq, 1);
    cyc(30);
    chk("R12 scl held", {scl_drive_low, scl_bus}, 2'b10);
    hw(2'd0, 8'h01);
    chk("R12 scl released", scl_drive_low, 0);
    chk("R11 idle code", status, 8'hF8);

    // R3 table of received bytes
    for (int i = 0; i < 5; i++) begin
      hw(2'd0, {7'b0, RX_TBL[i][8]});
      m_wbyte(RX_TBL[i][16:9], a);
      chk("R3 ack bit", a, RX_TBL[i][8] ? 1'b0 : 1'b1);
      chk("R3 status", status, RX_TBL[i][7:0]);
      chk("R3 rx_data", rx_data, RX_TBL[i][16:9]);
      hw(2'd0, 8'h01);
    end
    m_stop(); cyc(10);
    chk("R3 not addressed after nack", irq, 0);

    // R8 stop after byte
    m_start(); m_wbyte(WR_A, a); hw(2'd0, 8'h01);
    m_wbyte(8'h11, a); chk("R3 ack 11", a, 0); hw(2'd0, 8'h01);
    m_stop(); cyc(10);
    chk("R8 stop code", status, 8'hA0); chk("R8 irq", irq, 1);
    hw(2'd0, 8'h01);

    // R8 repeated start, then R4/R5 read
    m_start(); m_wbyte(WR_A, a); hw(2'd0, 8'h01);
    m_rstart(); cyc(10);
    chk("R8 rstart code", status, 8'hA0);
    hw(2'd0, 8'h01);
    m_wbyte(RD_A, a);
    chk("R4 ack", a, 0); chk("R4 status", status, 8'hA8);
    hw(2'd2, 8'hC3); hw(2'd0, 8'h01);
    m_rbyte(1'b0, d);
    chk("R4 data msb first", d, 8'hC3); chk("R5 ack code", status, 8'hB8);
    hw(2'd2, 8'h96); hw(2'd0, 8'h01);
    m_rbyte(1'b1, d);
    chk("R5 data", d, 8'h96); chk("R5 nack code", status, 8'hC0);
    hw(2'd0, 8'h01);
    m_stop(); cyc(10);
    chk("R5 not addressed", irq, 0);

    // R6 acknowledge enable cleared during transmit
    m_start(); m_wbyte(RD_A, a); chk("R6 addr", status, 8'hA8);
    hw(2'd2, 8'h5E); hw(2'd0, 8'h00);
    m_rbyte(1'b0, d);
    chk("R6 last byte", d, 8'h5E); chk("R6 code", status, 8'hC8);
    hw(2'd0, 8'h00);
    m_rbyte(1'b1, d);
    chk("R6 all ones", d, 8'hFF); chk("R6 no irq", irq, 0);
    m_stop();

    // R7 own address ignored, then recognised again
    m_start(); m_wbyte(WR_A, a);
    chk("R7 nack", a, 1); chk("R7 no irq", irq, 0);
    m_stop();
    hw(2'd0, 8'h01);
    m_start(); m_wbyte(WR_A, a);
    chk("R7 resumed", status, 8'h60);
    hw(2'd0, 8'h01); m_stop(); hw(2'd0, 8'h01);

    // R9 STOP in middle of data byte, R10 recovery
    m_start(); m_wbyte(WR_A, a); hw(2'd0, 8'h01);
    m_wbit(1); m_wbit(0); m_wbit(1);
    m_stop(); cyc(10);
    chk("R9 error code", status, 8'h00); chk("R9 irq", irq, 1);
    chk("R9 lines free", {scl_drive_low, sda_drive_low}, 2'b00);
    hw(2'd0, 8'h05);
    chk("R10 status", status, 8'hF8);
    chk("R10 ctrl", ctrl_rd, 8'h01);
    chk("R10 lines", {scl_drive_low, sda_drive_low}, 2'b00);
    m_start(); m_wbyte(WR_A, a);
    chk("R10 addr after recovery", status, 8'h60);
    hw(2'd0, 8'h01); m_stop(); hw(2'd0, 8'h01);

    // R9 START inside address byte
    m_start(); m_wbit(1); m_wbit(0); m_wbit(1); m_wbit(0);
    m_rstart(); cyc(10);
    chk("R9 addr error", status, 8'h00);
    hw(2'd0, 8'h05);
    m_stop(); cyc(10);
    chk("R10 idle after", {irq, status}, {1'b0, 8'hF8});

    finish_run();
  end
endmodule